// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block carries out one memory access at a time between a processor's address holding register (MAR) and its data holding register (MDR) on one side and an external memory bus on the other. The processor raises `req` for one clock with a direction select, an address and, for stores, the data to store. The block loads MAR and, for stores, MDR from these inputs. It then runs a strictly ordered bus cycle. For loads it returns the fetched word in MDR, which appears on `rdata`, and it reports completion with a single-clock `done` pulse.

Every bus cycle passes through four named states. **IDLE** waits for a request. The transition *accept* (`req` high in IDLE) loads MAR and MDR and moves to **SETUP**. SETUP places MAR on the address bus and, for stores, enables MDR onto the data-out bus while both strobes stay low. The transition *launch* is unconditional and moves to **STROBE**, which raises the read or write strobe. STROBE stays put while `bus_rdy` is low (*hold*). When `bus_rdy` is high it takes the transition *complete*: on that edge a load copies `bus_din` into MDR, and the state becomes **FINISH**. In FINISH both strobes are low and `done` is high. The transition *retire* is unconditional and returns to IDLE.

Top module: `membus_seq`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the block in IDLE. Both strobes, `bus_doe` and `done` are low, and MAR and MDR are zero, so `bus_addr` and `rdata` read 0.
- R2: When `req` is high in IDLE, the next clock is SETUP. In SETUP `bus_addr` equals the requested address and both strobes are low. For a store (`wr_sel`=1), `bus_doe` is 1 and `bus_dout` equals the requested data.
- R3: The strobe rises in the clock after SETUP. It is `bus_wr` when `wr_sel` was 1 and `bus_rd` when it was 0. Address and store data are the same as in SETUP.
- R4: A strobe stays high for every clock in which `bus_rdy` is low. It is high for at least one clock even when `bus_rdy` is already high. It is therefore high for exactly N+1 clocks when `bus_rdy` rises in its (N+1)-th clock.
- R5: A load copies `bus_din` into MDR on the edge where `bus_rd` and `bus_rdy` are both high. In the following clock `bus_rd` is low and `rdata` already shows the captured word.
- R6: During a store strobe, `bus_addr` and `bus_dout` do not change. The strobe falls on the edge after the first clock with `bus_rdy` high.
- R7: `bus_doe` is high only in stores, from SETUP through FINISH. It is low during loads and in IDLE.
- R8: `done` is high for exactly one clock: the first clock with both strobes low after the strobe phase. The block is back in IDLE in the next clock.
- R9: `req`, `wr_sel`, `req_addr` and `req_wdata` have no effect outside IDLE. The address, data, strobe kind and strobe length of the running cycle are unchanged, and no extra cycle follows.
- R10: `bus_rd` and `bus_wr` are never high together. After a store, MDR (`rdata`) still holds the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Start a cycle (taken only in IDLE) |
| wr_sel | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Address loaded into MAR |
| req_wdata | input | DW | Store data loaded into MDR |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | MDR contents |
| bus_addr | output | AW | Memory address bus (MAR) |
| bus_dout | output | DW | Memory data-out bus (MDR) |
| bus_doe | output | 1 | Data-out enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_din | input | DW | Memory data-in bus |
| bus_rdy | input | 1 | Memory ready |

## Verification
The assertions assume that memory holds `bus_din` valid whenever it raises `bus_rdy` under a read strobe. They also assume that `bus_rdy` may be high at any time, including outside a strobe, and that the requester may raise `req` in any state. The bench memory model meets these conditions. It drives inverted data whenever no read strobe is present, so an early or late capture shows up as a mismatch. It raises ready after a configurable delay of 0 to 3 strobe clocks, or holds ready high at all times. On alternate cycles the bench keeps `req` high with inverted address, data and direction for the whole busy period.

// File: rtl/membus_pkg.sv
package membus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_FINISH
    } bus_state_t;
endpackage

// File: rtl/membus_fsm.sv
module membus_fsm
    import membus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic wr_sel,
    input  logic bus_rdy,
    output logic load,
    output logic capture,
    output logic strobe_rd,
    output logic strobe_wr,
    output logic doe,
    output logic done
);
    bus_state_t state_q;
    bus_state_t state_d;
    logic       write_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) write_q <= wr_sel;
        end
    end

    // transitions: accept, launch, hold, complete, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (bus_rdy) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        capture   = 1'b0;
        strobe_rd = 1'b0;
        strobe_wr = 1'b0;
        doe       = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = req;
            ST_SETUP:  doe  = write_q;
            ST_STROBE: begin
                strobe_rd = !write_q;
                strobe_wr = write_q;
                doe       = write_q;
                capture   = !write_q && bus_rdy;
            end
            ST_FINISH: begin
                doe  = write_q;
                done = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/membus_regs.sv
module membus_regs #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          wr_sel,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mdr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
            mdr <= '0;
        end else begin
            if (load) begin
                mar <= req_addr;
                if (wr_sel) mdr <= req_wdata;
            end else if (capture) begin
                mdr <= bus_din;
            end
        end
    end
endmodule

// File: rtl/membus_seq.sv
module membus_seq #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          wr_sel,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_rdy
);
    logic          load;
    logic          capture;
    logic [AW-1:0] mar;
    logic [DW-1:0] mdr;

    membus_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wr_sel    (wr_sel),
        .bus_rdy   (bus_rdy),
        .load      (load),
        .capture   (capture),
        .strobe_rd (bus_rd),
        .strobe_wr (bus_wr),
        .doe       (bus_doe),
        .done      (done)
    );

    membus_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .wr_sel    (wr_sel),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .bus_din   (bus_din),
        .mar       (mar),
        .mdr       (mdr)
    );

    assign bus_addr = mar;
    assign bus_dout = mdr;
    assign rdata    = mdr;
endmodule

// File: rtl/membus_chk.sv
module membus_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic [DW-1:0] rdata,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_dout,
    input logic          bus_doe,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [DW-1:0] bus_din,
    input logic          bus_rdy
);
    logic strobe;
    assign strobe = bus_rd | bus_wr;

    // R10
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R3
    strobe_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe) |-> $stable(bus_addr) && $stable(bus_dout));

    // R3
    write_data_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr) |-> $past(bus_doe));

    // R4
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !bus_rdy) |=> (bus_rd == $past(bus_rd)) && (bus_wr == $past(bus_wr)));

    // R6
    strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && bus_rdy) |=> !strobe);

    // R5
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_rdy) |=> rdata == $past(bus_din));

    // R6
    strobe_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> $stable(bus_addr) && $stable(bus_dout));

    // R7
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_doe);

    // R8
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(strobe) && !strobe);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !bus_doe);
endmodule

bind membus_seq membus_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .rdata    (rdata),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_din  (bus_din),
    .bus_rdy  (bus_rdy)
);

// File: tb/sim_membus_seq.sv
module sim_membus_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       done;
    logic [7:0] rdata;
    logic [7:0] bus_addr;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic       bus_rd;
    logic       bus_wr;
    logic [7:0] bus_din;
    logic       bus_rdy;

    int checks = 0;
    int errors = 0;

    // memory model
    logic [7:0] mem [256];
    logic       mem_init = 1'b1;
    logic       force_rdy = 1'b0;
    int         wait_cfg = 0;
    int         scnt = 0;

    always #2 clk = ~clk;

    assign bus_rdy = force_rdy || ((bus_rd || bus_wr) && (scnt >= wait_cfg));
    assign bus_din = bus_rd ? mem[bus_addr] : ~mem[bus_addr];

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (bus_wr && bus_rdy) begin
            mem[bus_addr] <= bus_dout;
        end
        scnt <= (bus_rd || bus_wr) ? scnt + 1 : 0;
    end

    membus_seq #(.AW(8), .DW(8)) u0 (
        .clk(clk), .rst(rst), .req(req), .wr_sel(wr_sel),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one complete cycle; exp_w = expected strobe length, exp_rd = expected load data
    task automatic xfer(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input int w, input int exp_w, input logic noisy,
                        input logic [7:0] exp_rd);
        int width;
        @(negedge clk);
        req = 1'b1; wr_sel = wr; req_addr = a; req_wdata = d; wait_cfg = w;
        @(negedge clk);
        if (noisy) begin
            wr_sel = ~wr; req_addr = ~a; req_wdata = ~d;
        end else begin
            req = 1'b0;
        end
        // SETUP
        check(!bus_rd && !bus_wr && !done, "R2 strobes low", {bus_rd, bus_wr, done}, 0);
        check(bus_addr == a, "R2 address", bus_addr, a);
        check(bus_doe == wr, "R7 doe in setup", bus_doe, wr);
        if (wr) check(bus_dout == d, "R2 store data", bus_dout, d);
        width = 0;
        @(negedge clk);
        check(bus_rd == !wr && bus_wr == wr, "R3 strobe kind", {bus_rd, bus_wr}, {!wr, wr});
        while ((bus_rd || bus_wr) && width < 12) begin
            check(!(bus_rd && bus_wr), "R10 single strobe", {bus_rd, bus_wr}, {!wr, wr});
            check(bus_addr == a, "R9 address held", bus_addr, a);
            check(bus_doe == wr && !done, "R7 doe during strobe", {bus_doe, done}, {wr, 1'b0});
            if (wr) check(bus_dout == d, "R6 data held", bus_dout, d);
            width++;
            @(negedge clk);
        end
        req = 1'b0;
        // FINISH
        check(width == exp_w, "R4 strobe length", width, exp_w);
        check(done == 1'b1, "R8 done pulse", done, 1);
        check(bus_doe == wr, "R7 doe in finish", bus_doe, wr);
        if (wr) check(rdata == d, "R10 mdr keeps store", rdata, d);
        else    check(rdata == exp_rd, "R5 load data", rdata, exp_rd);
        @(negedge clk);
        check(!done && !bus_doe && !bus_rd && !bus_wr, "R8 back to idle",
              {done, bus_doe, bus_rd, bus_wr}, 0);
        check(bus_addr == a, "R9 no extra accept", bus_addr, a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mem_init = 1'b0;
        rst = 1'b0;
        // R1 reset state
        check(!bus_rd && !bus_wr && !bus_doe && !done, "R1 outputs idle",
              {bus_rd, bus_wr, bus_doe, done}, 0);
        check(rdata == 8'h00 && bus_addr == 8'h00, "R1 registers cleared", {rdata, bus_addr}, 0);

        // loads of initial contents
        for (int a = 0; a < 256; a++)
            xfer(1'b0, 8'(a), 8'h00, a % 4, (a % 4) + 1, a[0], 8'(a) ^ 8'h5A);
        // stores of an arithmetic pattern
        for (int a = 0; a < 256; a++)
            xfer(1'b1, 8'(a), 8'(a * 7 + 3), (a >> 2) % 4, ((a >> 2) % 4) + 1, a[1], 8'h00);
        // read back
        for (int a = 0; a < 256; a++)
            xfer(1'b0, 8'(a), 8'h00, (a >> 1) % 4, ((a >> 1) % 4) + 1, !a[0], 8'(a * 7 + 3));

        // ready already high: one-clock strobe (R4)
        force_rdy = 1'b1;
        for (int a = 0; a < 16; a++) begin
            xfer(1'b1, 8'(a * 13), 8'(a * 29 + 1), 3, 1, a[0], 8'h00);
            xfer(1'b0, 8'(a * 13), 8'h00, 3, 1, !a[0], 8'(a * 29 + 1));
        end
        force_rdy = 1'b0;

        // R1 reset in the middle of a store
        @(negedge clk);
        req = 1'b1; wr_sel = 1'b1; req_addr = 8'h44; req_wdata = 8'hC3; wait_cfg = 3;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check(bus_wr == 1'b1, "R3 strobe before reset", bus_wr, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!bus_rd && !bus_wr && !bus_doe && !done, "R1 reset aborts",
              {bus_rd, bus_wr, bus_doe, done}, 0);
        check(rdata == 8'h00 && bus_addr == 8'h00, "R1 registers cleared again", {rdata, bus_addr}, 0);
        xfer(1'b0, 8'h10, 8'h00, 2, 3, 1'b0, 8'(16 * 7 + 3));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule